// File: doc/BRIEF.md
# Arithmetic Logic Cluster Slice

This block models one programmable logic cluster made of a parameterized number of logic elements (sixteen by default). Every element is set up for arithmetic work. Each has a pair of three-input lookup tables: one forms the sum bit and one forms the carry bit. Both tables read the element's two data bits and the incoming carry. The carries ripple from element 0 up to the last element, and the final carry leaves the cluster so that a following cluster can extend the chain. The two table masks are parameters. With the default masks the cluster is a plain binary adder.

Each element also owns one output register. The cluster exposes both the combinational sum and the registered sum. All registers share one clock, one enable, one active-low asynchronous clear, one synchronous clear and one synchronous load. A load takes either an external load word or the neighbouring register's value through the register chain, which turns the cluster into a shift register. A feedback select routes each register back into the first table input in place of the external operand, so the cluster can act as an accumulator or a counter.

Top module: `lab_arith_slice`

## Requirements
- R1: With the default masks (sum 8'h96, carry 8'hE8, table index {a,b,carry-in} with a as the MSB) and `fb_sel` low, {`carry_out`,`sum_comb`} equals `op_a + op_b + carry_in`.
- R2: The carry ripples from element 0 to element N-1, and `carry_out` is the carry of element N-1. For example, an all-ones `op_a` with `op_b`=0 and `carry_in`=1 gives `sum_comb`=0 and `carry_out`=1.
- R3: On a rising clock edge with `en` high and both `s_clr` and `s_load` low, `q` takes the value `sum_comb` had before the edge.
- R4: On an edge with `en` high and `s_clr` high, every register becomes 0, whatever `s_load` is.
- R5: On an edge with `en` high, `s_clr` low, `s_load` high and `chain_sel` low, `q` takes `load_word`.
- R6: On an edge with `en` high, `s_clr` low, `s_load` high and `chain_sel` high, `q[i]` takes the old `q[i-1]` and `q[0]` takes `chain_in`. `chain_out` always equals `q[N-1]`.
- R7: While `en` is low, `q` holds its value across edges, and `sum_comb`/`carry_out` still follow the inputs.
- R8: While `rst_n` is low, `q` is 0 without any clock edge. After `rst_n` rises, the registers stay cleared through the next two rising edges and first capture on the third.
- R9: With `fb_sel` high, each element's first table input is its own register output. With default masks, `sum_comb` is therefore `q + op_b + carry_in`, and repeated captures accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| rst_n | input | 1 | Active-low asynchronous clear of all registers |
| en | input | 1 | Cluster clock enable |
| s_clr | input | 1 | Synchronous clear, highest synchronous priority |
| s_load | input | 1 | Synchronous load |
| chain_sel | input | 1 | Load source: 1 register chain, 0 load word |
| fb_sel | input | 1 | 1 routes register outputs into the first table input |
| op_a | input | N_LE | First operand bits, one per element |
| op_b | input | N_LE | Second operand bits, one per element |
| load_word | input | N_LE | Synchronous load data, one bit per element |
| chain_in | input | 1 | Register-chain input to element 0 |
| carry_in | input | 1 | Carry into element 0 |
| sum_comb | output | N_LE | Unregistered table sums |
| q | output | N_LE | Registered outputs |
| carry_out | output | 1 | Carry from the last element |
| chain_out | output | 1 | Register-chain output (last element's register) |

## Verification
The synchronous clear and the synchronous load can both be asserted at the same edge. Feedback accumulation and a register load can also meet: the load discards the sum that the registers fed back. The bench raises `s_clr`, `s_load` and `fb_sel` at random in the same cycles, with `en` sometimes low. A reference model applies clear over load over sum, and it predicts both the combinational result of the current cycle and the register value after the edge. Directed cases add a clear held together with a load, a chain shift, and an asynchronous clear taken in the middle of a cycle.

// File: rtl/lab_arith_pkg.sv
package lab_arith_pkg;

  // Look up one bit of an 8-entry truth table; index is {a, b, c}.
  function automatic logic lut3(input logic [7:0] mask,
                                input logic a, input logic b, input logic c);
    logic [2:0] idx;
    idx = {a, b, c};
    return mask[idx];
  endfunction

  localparam logic [7:0] MASK_XOR3 = 8'h96;
  localparam logic [7:0] MASK_MAJ3 = 8'hE8;

endpackage

// File: rtl/lab_rst_sync.sv
module lab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/lab_le_lut.sv
module lab_le_lut
  import lab_arith_pkg::*;
#(
  parameter logic [7:0] SUM_MASK   = MASK_XOR3,
  parameter logic [7:0] CARRY_MASK = MASK_MAJ3
) (
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic sum_o,
  output logic carry_o
);
  always_comb begin
    sum_o   = lut3(SUM_MASK,   in_a, in_b, in_c);
    carry_o = lut3(CARRY_MASK, in_a, in_b, in_c);
  end
endmodule

// File: rtl/lab_le_reg.sv
module lab_le_reg (
  input  logic clk,
  input  logic clr_n,
  input  logic en,
  input  logic s_clr,
  input  logic s_load,
  input  logic chain_sel,
  input  logic d_sum,
  input  logic d_load,
  input  logic d_chain,
  output logic q_o
);
  logic q_r;
  logic q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) begin
      if (s_clr)       q_nxt = 1'b0;
      else if (s_load) q_nxt = chain_sel ? d_chain : d_load;
      else             q_nxt = d_sum;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_r <= 1'b0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  AST_SCLR_WINS: assert property (@(posedge clk) disable iff (!clr_n)
    (en && s_clr) |=> (q_o == 1'b0)); // R4
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!clr_n)
    (en && !s_clr && s_load && !chain_sel) |=> (q_o == $past(d_load))); // R5
  AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (!clr_n)
    (en && !s_clr && s_load && chain_sel) |=> (q_o == $past(d_chain))); // R6
  AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (!clr_n)
    (en && !s_clr && !s_load) |=> (q_o == $past(d_sum))); // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!clr_n)
    (!en) |=> $stable(q_o)); // R7

endmodule

// File: rtl/lab_arith_slice.sv
module lab_arith_slice
  import lab_arith_pkg::*;
#(
  parameter int         N_LE       = 16,
  parameter logic [7:0] SUM_MASK   = MASK_XOR3,
  parameter logic [7:0] CARRY_MASK = MASK_MAJ3,
  parameter int         SYNC_STG   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            s_clr,
  input  logic            s_load,
  input  logic            chain_sel,
  input  logic            fb_sel,
  input  logic [N_LE-1:0] op_a,
  input  logic [N_LE-1:0] op_b,
  input  logic [N_LE-1:0] load_word,
  input  logic            chain_in,
  input  logic            carry_in,
  output logic [N_LE-1:0] sum_comb,
  output logic [N_LE-1:0] q,
  output logic            carry_out,
  output logic            chain_out
);
  localparam int CW = N_LE + 1;
  localparam bit DEFAULT_MASKS = (SUM_MASK == MASK_XOR3) && (CARRY_MASK == MASK_MAJ3);

  logic            clr_n_int;
  logic [CW-1:0]   carry_vec;
  logic [N_LE-1:0] a_eff;
  logic [N_LE-1:0] chain_src;

  lab_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (clr_n_int)
  );

  assign carry_vec[0] = carry_in;

  genvar gi;
  generate
    for (gi = 0; gi < N_LE; gi++) begin : g_le
      assign a_eff[gi] = fb_sel ? q[gi] : op_a[gi];

      if (gi == 0) begin : g_head
        assign chain_src[gi] = chain_in;
      end else begin : g_body
        assign chain_src[gi] = q[gi-1];
      end

      lab_le_lut #(
        .SUM_MASK   (SUM_MASK),
        .CARRY_MASK (CARRY_MASK)
      ) u_lut (
        .in_a    (a_eff[gi]),
        .in_b    (op_b[gi]),
        .in_c    (carry_vec[gi]),
        .sum_o   (sum_comb[gi]),
        .carry_o (carry_vec[gi+1])
      );

      lab_le_reg u_reg (
        .clk       (clk),
        .clr_n     (clr_n_int),
        .en        (en),
        .s_clr     (s_clr),
        .s_load    (s_load),
        .chain_sel (chain_sel),
        .d_sum     (sum_comb[gi]),
        .d_load    (load_word[gi]),
        .d_chain   (chain_src[gi]),
        .q_o       (q[gi])
      );
    end
  endgenerate

  assign carry_out = carry_vec[N_LE];
  assign chain_out = q[N_LE-1];

  AST_ASYNC_CLEAR: assert property (@(posedge clk)
    (!rst_n) |-> (q == '0)); // R8

  generate
    if (DEFAULT_MASKS) begin : g_add_chk
      AST_ADD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_sel) |-> ({carry_out, sum_comb} == ({1'b0, op_a} + {1'b0, op_b} + CW'(carry_in)))); // R1
      AST_ACC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_sel) |-> ({carry_out, sum_comb} == ({1'b0, q} + {1'b0, op_b} + CW'(carry_in)))); // R9
    end
  endgenerate

endmodule

// File: tb/lab_arith_slice_bench.sv
module lab_arith_slice_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n, en, s_clr, s_load, chain_sel, fb_sel, chain_in, carry_in;
  logic [N-1:0] op_a, op_b, load_word, sum_comb, q;
  logic carry_out, chain_out;

  int total = 0;
  int bad = 0;
  logic [N-1:0] q_exp;

  always #4 clk = ~clk;

  lab_arith_slice u_lab_arith_slice (
    .clk(clk), .rst_n(rst_n), .en(en), .s_clr(s_clr), .s_load(s_load),
    .chain_sel(chain_sel), .fb_sel(fb_sel), .op_a(op_a), .op_b(op_b),
    .load_word(load_word), .chain_in(chain_in), .carry_in(carry_in),
    .sum_comb(sum_comb), .q(q), .carry_out(carry_out), .chain_out(chain_out)
  );

  function automatic logic [N:0] add_model(logic [N-1:0] a, logic [N-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + (N+1)'(c);
  endfunction

  function automatic logic [N-1:0] next_model(logic [N-1:0] cur, logic e, logic sc, logic sl,
                                               logic cs, logic [N-1:0] ld, logic chi,
                                               logic [N-1:0] sm);
    if (!e) return cur;
    if (sc) return '0;
    if (sl) return cs ? {cur[N-2:0], chi} : ld;
    return sm;
  endfunction

  task automatic check(string req, logic [N:0] act, logic [N:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational result, then registered result.
  task automatic step(logic [N-1:0] a, logic [N-1:0] b, logic ci, logic e, logic sc,
                      logic sl, logic cs, logic fb, logic [N-1:0] ld, logic chi);
    logic [N:0] s;
    string rq;
    op_a = a; op_b = b; carry_in = ci; en = e; s_clr = sc; s_load = sl;
    chain_sel = cs; fb_sel = fb; load_word = ld; chain_in = chi;
    #1;
    s = add_model(fb ? q_exp : a, b, ci);
    check(fb ? "R9 comb" : "R1 comb", {carry_out, sum_comb}, s);
    if (!e)       rq = "R7 hold";
    else if (sc)  rq = "R4 clear";
    else if (sl)  rq = cs ? "R6 chain" : "R5 load";
    else          rq = fb ? "R9 accum" : "R3 capture";
    q_exp = next_model(q_exp, e, sc, sl, cs, ld, chi, s[N-1:0]);
    @(posedge clk);
    @(negedge clk);
    check(rq, {1'b0, q}, {1'b0, q_exp});
    check("R6 chain_out", {{N{1'b0}}, chain_out}, {{N{1'b0}}, q_exp[N-1]});
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b1; s_clr = 1'b0; s_load = 1'b0; chain_sel = 1'b0;
    fb_sel = 1'b0; op_a = 16'd5; op_b = 16'd3; load_word = '0; chain_in = 1'b0;
    carry_in = 1'b0; q_exp = '0;
    repeat (3) @(negedge clk);
    check("R8 reset q", {1'b0, q}, '0);
    // R8: synchronized release, two clearing edges then capture
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 release edge1", {1'b0, q}, '0);
    @(posedge clk); @(negedge clk);
    check("R8 release edge2", {1'b0, q}, '0);
    @(posedge clk); @(negedge clk);
    check("R8 first capture", {1'b0, q}, 17'd8);
    q_exp = 16'd8;

    // R2: full ripple
    step(16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    check("R2 ripple carry", {carry_out, sum_comb}, {1'b1, 16'h0000});
    // R4: clear beats load
    step(16'h1234, 16'h1111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hBEEF, 1'b0);
    step(16'h1234, 16'h1111, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hCAFE, 1'b1);
    // R7: hold while inputs change
    step(16'h00FF, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    step(16'h7000, 16'h9000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    step(16'h0001, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hAAAA, 1'b0);
    // R6: shift a one through the chain
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    for (int i = 0; i < N + 1; i++)
      step(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, (i == 0));
    // R9: accumulate 3 per cycle
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 10; i++)
      step(16'hFFFF, 16'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0, 1'b0);
    check("R9 accum total", {1'b0, q}, 17'd30);

    // R8: asynchronous clear mid-cycle
    step(16'h4321, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    #2 rst_n = 1'b0;
    #1 check("R8 async clear", {1'b0, q}, '0);
    q_exp = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 hold after release", {1'b0, q}, '0);
    @(posedge clk); @(negedge clk);

    // random mix: clear, load, chain, feedback and enable in the same cycles
    for (int i = 0; i < 400; i++) begin
      step(16'($urandom), 16'($urandom), 1'($urandom),
           ($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
           1'($urandom), ($urandom % 3) == 0, 16'($urandom), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule